// File: doc/BRIEF.md
# Multi-Lane Serial Flash Fast-Read Front End

This block is the slave-side command front end of a serial flash memory. It sits behind the flash pads and sees the serial clock, an active-low select and four data lanes. It takes in a one-byte command. For the five fast-read commands it handles, it then takes a 24-bit address on one, two or four lanes, waits a command-specific number of dummy clocks and streams bytes from the memory array out on two or four lanes. The stream continues until the select is raised.

All pad inputs are brought into the block clock domain through a synchronizer, and the block detects the serial clock edges there. The serial clock half-period must therefore be at least six block clocks. Read data comes from the array through a request handshake. `rd_valid` holds its request, with `rd_addr` stable, until `rd_ready` is seen high. The byte must appear on `rd_data` in the cycle after that handshake. Back-pressure is allowed, but the memory must answer within the dummy window and within one byte time of the stream. The serial clock cannot be stalled, so the block has no way to wait longer.

Top module: `flash_read_fe`

## Requirements
- R1: Both idle clock levels are accepted (serial clock low or high when the select falls). Lanes are sampled on rising serial clock edges. Output lanes change only after falling edges.
- R2: The command byte is taken most significant bit first on lane 0, one bit per rising edge, for eight edges.
- R3: Command 3Bh takes the address on lane 0 alone and waits 8 dummy clocks. It then returns data on two lanes: lane 1 carries the higher bit of each pair, and bit 7 is sent first.
- R4: Command BBh takes the address two bits per clock, with lane 1 as the more significant bit. It waits 4 dummy clocks and returns data as in R3.
- R5: Command 6Bh takes the address on lane 0 alone and waits 8 dummy clocks. It then returns data on four lanes: lane 3 holds the most significant bit of each nibble, and the high nibble is sent first.
- R6: Commands EBh and E7h take the address four bits per clock, with lane 3 most significant, and return data as in R5. EBh waits 4 dummy clocks and E7h waits 2.
- R7: A four-lane command (6Bh, EBh, E7h) received while `qe` is 0 is ignored. So is any other command byte. For the rest of that selection no lane is enabled and no memory request is made.
- R8: No lane is enabled during the command, address or dummy clocks. During data, the enables are 0011b for two-lane commands and 1111b for four-lane commands.
- R9: Each byte streamed advances the read address by one, and the address wraps from 1FFFFFh to 000000h. Address bits 23 to 21 are ignored.
- R10: Raising the select at any point ends the command and clears every lane enable at once. The next selection starts a fresh command.
- R11: A memory request is held, with its address stable, until accepted. Each streamed byte comes from one accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, sampling the pads |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock pad |
| cs_n | input | 1 | Active-low select pad |
| io_in | input | 4 | Lane input values from the pads |
| io_out | output | 4 | Lane output values to the pads |
| io_oe | output | 4 | Per-lane output enables |
| qe | input | 1 | Four-lane enable status bit |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory read request accepted |
| rd_addr | output | 24 | Memory read byte address |
| rd_data | input | 8 | Read byte, valid the cycle after acceptance |

## Verification
Every command byte is driven with the status bit both set and cleared, under both idle clock levels, from a zero address and from a mixed-bit address. These runs separate lane ordering errors, wrong dummy counts and a missing four-lane gate. Unknown command bytes show whether decode falls through. A start two bytes below the top of the array, and an address with its top three bits set, separate wrap and masking faults from plain increment. Memory acceptance is throttled throughout, and one selection is cut off mid-command, so a held request or counters left over from the previous selection show up in the next read.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int CMD_W  = 8;

  localparam logic [CMD_W-1:0] OP_DUAL_OUT  = 8'h3B;
  localparam logic [CMD_W-1:0] OP_DUAL_IO   = 8'hBB;
  localparam logic [CMD_W-1:0] OP_QUAD_OUT  = 8'h6B;
  localparam logic [CMD_W-1:0] OP_QUAD_IO   = 8'hEB;
  localparam logic [CMD_W-1:0] OP_QUAD_WORD = 8'hE7;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } fe_state_t;

  // lane widths are kept as log2: 0 = one lane, 1 = two, 2 = four
  typedef struct packed {
    logic       ok;
    logic [1:0] addr_lg;
    logic [1:0] data_lg;
    logic [3:0] dummy;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [CMD_W-1:0] op, input logic qe_bit);
    op_info_t r;
    r = '0;
    case (op)
      OP_DUAL_OUT:  r = '{ok: 1'b1,   addr_lg: 2'd0, data_lg: 2'd1, dummy: 4'd8};
      OP_DUAL_IO:   r = '{ok: 1'b1,   addr_lg: 2'd1, data_lg: 2'd1, dummy: 4'd4};
      OP_QUAD_OUT:  r = '{ok: qe_bit, addr_lg: 2'd0, data_lg: 2'd2, dummy: 4'd8};
      OP_QUAD_IO:   r = '{ok: qe_bit, addr_lg: 2'd2, data_lg: 2'd2, dummy: 4'd4};
      OP_QUAD_WORD: r = '{ok: qe_bit, addr_lg: 2'd2, data_lg: 2'd2, dummy: 4'd2};
      default:      r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fe_fetch.sv
module fe_fetch #(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 21,
  parameter int DW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              advance,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     buf_data
);

  localparam logic [ADDR_W-1:0] MASK = ADDR_W'((64'd1 << ARRAY_AW) - 64'd1);

  logic [ADDR_W-1:0] addr_q;
  logic              valid_q;
  logic              landed_q;
  logic [DW-1:0]     buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      valid_q  <= 1'b0;
      landed_q <= 1'b0;
      buf_q    <= '0;
    end else begin
      landed_q <= valid_q && rd_ready && !clear;
      if (landed_q) buf_q <= rd_data;
      if (clear) begin
        valid_q <= 1'b0;
      end else if (start) begin
        addr_q  <= start_addr & MASK;
        valid_q <= 1'b1;
      end else if (advance) begin
        addr_q  <= (addr_q + 1'b1) & MASK;
        valid_q <= 1'b1;
      end else if (valid_q && rd_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rd_valid = valid_q;
  assign rd_addr  = addr_q;
  assign buf_data = buf_q;

endmodule

// File: rtl/fe_lanes.sv
module fe_lanes
  import flash_fe_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [1:0]       data_lg,
  input  logic [DW-1:0]    buf_data,
  output logic [LANES-1:0] lane_out,
  output logic [LANES-1:0] lane_oe,
  output logic             take
);

  localparam int CW = $clog2(DW) + 1;
  localparam int IW = $clog2(DW);

  logic [DW-1:0]    sr_q;
  logic [DW-1:0]    src;
  logic [CW-1:0]    left_q;
  logic [CW-1:0]    slots;
  logic [LANES-1:0] out_q;
  logic [LANES-1:0] oe_q;
  logic [LANES-1:0] nxt_out;
  logic [LANES-1:0] nxt_oe;
  logic             take_q;
  int               width;

  always_comb begin
    width   = 1 << data_lg;
    src     = (left_q == '0) ? buf_data : sr_q;
    slots   = CW'(DW >> data_lg);
    nxt_out = '0;
    nxt_oe  = '0;
    if (data_lg == 2'd0) begin
      nxt_out[1] = src[DW-1];
      nxt_oe[1]  = 1'b1;
    end else begin
      for (int j = 0; j < LANES; j++) begin
        if (j < width) begin
          nxt_out[j] = src[IW'(DW - width + j)];
          nxt_oe[j]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
      out_q  <= '0;
      oe_q   <= '0;
      take_q <= 1'b0;
    end else if (clear) begin
      sr_q   <= '0;
      left_q <= '0;
      out_q  <= '0;
      oe_q   <= '0;
      take_q <= 1'b0;
    end else begin
      take_q <= 1'b0;
      if (step) begin
        out_q  <= nxt_out;
        oe_q   <= nxt_oe;
        sr_q   <= src << width;
        take_q <= (left_q == '0);
        left_q <= (left_q == '0) ? slots - 1'b1 : left_q - 1'b1;
      end
    end
  end

  assign lane_out = out_q;
  assign lane_oe  = oe_q;
  assign take     = take_q;

endmodule

// File: rtl/flash_read_fe.sv
module flash_read_fe
  import flash_fe_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int ARRAY_AW    = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic [LANES-1:0]  io_in,
  output logic [LANES-1:0]  io_out,
  output logic [LANES-1:0]  io_oe,
  input  logic              qe,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam int            SW       = LANES + 2;
  localparam int            CNT_W    = $clog2(ADDR_W) + 1;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

  logic [SW-1:0] pins_raw;
  logic [SW-1:0] pins_s;

  assign pins_raw = {cs_n, sclk, io_in};

  generate
    if (SYNC_STAGES > 0) begin : g_sync
      fe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s)
      );
    end else begin : g_nosync
      assign pins_s = pins_raw;
    end
  endgenerate

  logic             cs_s;
  logic             sclk_s;
  logic [LANES-1:0] io_s;
  logic             sclk_d;
  logic             sclk_rise;
  logic             sclk_fall;

  assign cs_s   = pins_s[SW-1];
  assign sclk_s = pins_s[SW-2];
  assign io_s   = pins_s[LANES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s && !sclk_d && !cs_s;
  assign sclk_fall = !sclk_s && sclk_d && !cs_s;

  fe_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] cmd_q;
  logic [CMD_W-1:0] cmd_next;
  logic [ADDR_W-1:0] sr_q;
  logic [ADDR_W-1:0] addr_next;
  logic [CNT_W-1:0]  addr_last;
  op_info_t          info_q;
  op_info_t          dec;

  assign cmd_next = {cmd_q[CMD_W-2:0], io_s[0]};
  assign dec      = decode_op(cmd_next, qe);

  always_comb begin
    case (info_q.addr_lg)
      2'd1:    addr_next = {sr_q[ADDR_W-3:0], io_s[1:0]};
      2'd2:    addr_next = {sr_q[ADDR_W-5:0], io_s[3:0]};
      default: addr_next = {sr_q[ADDR_W-2:0], io_s[0]};
    endcase
    addr_last = CNT_W'((ADDR_W >> info_q.addr_lg) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      sr_q    <= '0;
      info_q  <= '0;
    end else if (cs_s) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      cmd_q   <= '0;
      sr_q    <= '0;
      info_q  <= '0;
    end else if (sclk_rise) begin
      case (state_q)
        ST_CMD: begin
          cmd_q <= cmd_next;
          if (cnt_q == CNT_W'(CMD_W - 1)) begin
            cnt_q   <= '0;
            info_q  <= dec;
            state_q <= dec.ok ? ST_ADDR : ST_IGNORE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ADDR: begin
          sr_q <= addr_next;
          if (cnt_q == addr_last) begin
            cnt_q   <= '0;
            state_q <= ST_DUMMY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DUMMY: begin
          if ((cnt_q + 1'b1) == CNT_W'(info_q.dummy)) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA, ST_IGNORE: ;
        default: state_q <= ST_IGNORE;
      endcase
    end
  end

  logic              start_fetch;
  logic              data_step;
  logic              take;
  logic [BYTE_W-1:0] buf_data;
  logic [LANES-1:0]  lane_out;
  logic [LANES-1:0]  lane_oe;

  assign start_fetch = sclk_rise && (state_q == ST_ADDR) && (cnt_q == addr_last);
  assign data_step   = sclk_fall && (state_q == ST_DATA) && info_q.ok;

  fe_fetch #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .DW(BYTE_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cs_s),
    .start     (start_fetch),
    .start_addr(addr_next),
    .advance   (take),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .buf_data  (buf_data)
  );

  fe_lanes #(.DW(BYTE_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cs_s),
    .step    (data_step),
    .data_lg (info_q.data_lg),
    .buf_data(buf_data),
    .lane_out(lane_out),
    .lane_oe (lane_oe),
    .take    (take)
  );

  assign io_out = lane_out;
  assign io_oe  = lane_oe & {LANES{~cs_n}};

endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int ADDR_W   = 24,
  parameter int ARRAY_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              qe,
  input logic [3:0]        io_oe,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr
);

  // R10: deselect leaves no lane driven
  p_oe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));

  // R8: only the lane groups a command can use are ever enabled
  p_lane_set_r8: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

  // R7: upper lanes are driven only while four-lane reads are allowed
  p_quad_gate_r7: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (io_oe[3] || io_oe[2]) |-> qe);

  // R11: a request not yet accepted stays up with the same address
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R9: requests never leave the array
  p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
    rd_valid |-> ((rd_addr >> ARRAY_AW) == '0));

endmodule

bind flash_read_fe fe_checker #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .qe      (qe),
  .io_oe   (io_oe),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_addr (rd_addr)
);

// File: tb/sim_flash_read_fe.sv
`timescale 1ns/1ps
module sim_flash_read_fe;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  io_in = 4'b0;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic        qe = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data = 8'h00;

  int    checks = 0;
  int    fails = 0;
  int    hs_cnt = 0;
  int    rc = 0;
  bit    done = 1'b0;
  string note = "";

  always #2 clk = ~clk;

  flash_read_fe u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .qe(qe),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_byte(input logic [20:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
  endfunction

  // memory model with throttled acceptance
  always @(posedge clk) begin
    rc <= rc + 1;
    rd_ready <= (rc % 3) != 2;
    if (rd_valid && rd_ready) begin
      rd_data <= mem_byte(rd_addr[20:0]);
      hs_cnt  <= hs_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] v, output logic [3:0] so, output logic [3:0] soe);
    sclk  = 1'b0;
    io_in = v;
    repeat (8) @(negedge clk);
    so  = io_out;
    soe = io_oe;
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] op, input logic [23:0] a, input int nb,
                      input bit m3, input bit q);
    int alg, dlg, nd, hs0;
    bit quad, known, accept, oe_clean;
    logic [3:0] so, soe, oe_exp;
    string rq;
    known = 1'b1; quad = 1'b0;
    case (op)
      8'h3B: begin alg = 0; dlg = 1; nd = 8; rq = "R3"; end
      8'hBB: begin alg = 1; dlg = 1; nd = 4; rq = "R4"; end
      8'h6B: begin alg = 0; dlg = 2; nd = 8; quad = 1'b1; rq = "R5"; end
      8'hEB: begin alg = 2; dlg = 2; nd = 4; quad = 1'b1; rq = "R6"; end
      8'hE7: begin alg = 2; dlg = 2; nd = 2; quad = 1'b1; rq = "R6"; end
      default: begin alg = 0; dlg = 1; nd = 8; known = 1'b0; rq = "R7"; end
    endcase
    accept = known && (!quad || q);
    if (!accept) rq = "R7";
    qe   = q;
    sclk = m3;
    repeat (4) @(negedge clk);
    hs0  = hs_cnt;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_clean = 1'b1;
    // R2: command on lane 0, MSB first
    for (int i = 7; i >= 0; i--) begin
      tick({3'b000, op[i]}, so, soe);
      if (soe != 4'b0) oe_clean = 1'b0;
    end
    for (int k = 0; k < (24 >> alg); k++) begin
      logic [23:0] t;
      logic [3:0]  v;
      t = a << (k << alg);
      if (alg == 0)      v = {3'b000, t[23]};
      else if (alg == 1) v = {2'b00, t[23:22]};
      else               v = t[23:20];
      tick(v, so, soe);
      if (soe != 4'b0) oe_clean = 1'b0;
    end
    for (int d = 0; d < nd; d++) begin
      tick(4'b0, so, soe);
      if (soe != 4'b0) oe_clean = 1'b0;
    end
    chk(oe_clean, $sformatf("R8 lanes idle before data op=%0h", op), 32'(oe_clean), 32'd1);
    oe_exp = accept ? ((dlg == 1) ? 4'b0011 : 4'b1111) : 4'b0000;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] got, exp;
      bit oe_ok;
      got = 8'h00;
      oe_ok = 1'b1;
      for (int s = 0; s < (8 >> dlg); s++) begin
        tick(4'b0, so, soe);
        if (soe != oe_exp) oe_ok = 1'b0;
        got = (dlg == 1) ? {got[5:0], so[1:0]} : {got[3:0], so[3:0]};
      end
      chk(oe_ok, $sformatf("R8 %s data enables op=%0h byte%0d", rq, op, b), 32'(oe_ok), 32'd1);
      if (accept) begin
        exp = mem_byte(21'(a + 24'(b)));
        chk(got == exp, $sformatf("%s/R2/R1 %s op=%0h mode%0d addr=%0h byte%0d",
                                  rq, note, op, m3 ? 3 : 0, a, b), 32'(got), 32'(exp));
      end
    end
    if (!m3) begin
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk(io_oe == 4'b0, "R10 enables cleared on deselect", 32'(io_oe), 32'd0);
    repeat (8) @(negedge clk);
    if (accept)
      chk((hs_cnt - hs0) >= nb, "R11 accepted requests cover bytes", 32'(hs_cnt - hs0), 32'(nb));
    else
      chk(hs_cnt == hs0, "R7 ignored command made no request", 32'(hs_cnt - hs0), 32'd0);
  endtask

  initial begin
    logic [7:0]  ops [5];
    logic [23:0] addrs [2];
    logic [3:0]  so, soe;
    ops[0] = 8'h3B; ops[1] = 8'hBB; ops[2] = 8'h6B; ops[3] = 8'hEB; ops[4] = 8'hE7;
    addrs[0] = 24'h000000; addrs[1] = 24'h0A5C3F;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(io_oe == 4'b0 && !rd_valid, "R10 reset state", {27'd0, rd_valid, io_oe}, 32'd0);

    for (int o = 0; o < 5; o++)
      for (int qv = 0; qv < 2; qv++)
        for (int m = 0; m < 2; m++)
          for (int ai = 0; ai < 2; ai++)
            xfer(ops[o], addrs[ai], 3, m[0], qv[0]);

    xfer(8'h03, 24'h000100, 1, 1'b0, 1'b1);
    xfer(8'hAA, 24'h000100, 1, 1'b1, 1'b1);

    note = "R9 wrap";
    xfer(8'hEB, 24'h1FFFFE, 4, 1'b0, 1'b1);
    xfer(8'h3B, 24'h1FFFFF, 2, 1'b1, 1'b0);
    note = "R9 upper bits ignored";
    xfer(8'hE7, 24'hE00010, 2, 1'b0, 1'b1);
    xfer(8'hBB, 24'hFFFFFF, 2, 1'b1, 1'b0);

    // R10: selection cut short mid-command, next one starts clean
    note = "R10 after abort";
    sclk = 1'b0;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) tick(4'b0001, so, soe);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    xfer(8'hEB, 24'h012345, 2, 1'b0, 1'b1);
    xfer(8'h6B, 24'h1FFFFF, 2, 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule